// File: doc/BRIEF.md
# Wide Unsigned Multiplier Built From Asymmetric Tiles

This block forms the exact 512-bit product of two 256-bit unsigned operands. It uses no multiplier wider than 17 by 26 bits. The first operand is zero-extended to 272 bits and cut into sixteen 17-bit limbs. The second operand is zero-extended to 260 bits and cut into ten 26-bit limbs. There are two banks of ten tiles. In each issue cycle, every bank multiplies one first-operand limb by all ten second-operand limbs. Bank 0 takes the even limbs and bank 1 takes the odd limbs, so one operation is issued over eight cycles.

Each tile is a three-stage pipeline. In each bank, the ten tile outputs are aligned to their 26-bit weights and summed into a row. Each row is then shifted left by the bit offset of its first-operand limb and added into a wide accumulator. The accumulator is cleared implicitly by the first row of each operation. When the final row has been absorbed, the product is registered at the output and a one-cycle done strobe is raised.

A new operation may be accepted in the last issue cycle of the previous one. This gives a sustained rate of one product every eight cycles, with results delivered in acceptance order.

Top module: `wide_mul_tiled`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the full unsigned product `in_x * in_y` of the operands that were accepted for that result.
- R2: `out_valid` rises exactly 11 clock edges after the edge at which `in_valid` and `in_ready` were both high (8 issue cycles plus 3 tile stages).
- R3: The accumulator bits above bit 511 are zero whenever a product is completed.
- R4: After an accept, `in_ready` is low for 7 cycles and high again in the 8th cycle, which is the last issue cycle. While `in_ready` is low, `in_valid` and the operand inputs are ignored.
- R5: `out_valid` is high for exactly one cycle per accepted operation.
- R6: During and just after reset, `in_ready` is 1, `out_valid` is 0 and `out_prod` is 0.
- R7: Operations accepted back to back, one every 8 cycles, produce independent results in acceptance order. No partial sum carries over from one operation to the next.
- R8: `out_prod` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request to start a multiplication |
| in_ready | output | 1 | The block can take a request in this cycle |
| in_x | input | 256 | First operand, split into 17-bit limbs |
| in_y | input | 256 | Second operand, split into 26-bit limbs |
| out_valid | output | 1 | One-cycle strobe marking a new product |
| out_prod | output | 512 | Product of the matching accepted operands |

## Verification
The assertions depend on the controller holding the issue pattern. After every accept, eight consecutive tagged steps follow, and their step indices rise by one. Completions are therefore always at least eight cycles apart. This holds for any input sequence, because the block only samples `in_valid` when `in_ready` is high.

The stimulus keeps `in_valid` high through busy windows, with changing operands. This shows that requests arriving outside the ready window cannot break that spacing or corrupt a product. The operand set covers zeros, all-ones (the largest carry into the upper accumulator bits), single set bits at the ends of both operands, and random values.

// File: rtl/wm_pkg.sv
// Shared types for the tiled wide multiplier.
// Assumes no configuration needs more than 256 issue steps.
package wm_pkg;
    localparam int WM_STEP_W = 8;

    // Tag that travels beside the tile pipeline, identifying each row of partial products
    typedef struct packed {
        logic                 vld;
        logic                 first;
        logic                 last;
        logic [WM_STEP_W-1:0] step;
    } wm_tag_t;
endpackage

// File: rtl/wm_tile.sv
// Unsigned AW x BW multiplier tile with LAT register stages.
// Stage 1 registers the inputs and stage 2 registers the product.
// Any further stages only delay the product. Assumes LAT >= 2.
module wm_tile #(
    parameter int AW  = 17,
    parameter int BW  = 26,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [AW+BW-1:0] p
);
    localparam int PW = AW + BW;

    logic [AW-1:0] a_r;
    logic [BW-1:0] b_r;
    logic [PW-1:0] pipe [LAT-1];

    // Register the operands, then the product, then any extra delay stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r <= '0;
            b_r <= '0;
            for (int k = 0; k < LAT-1; k++) pipe[k] <= '0;
        end else begin
            a_r     <= a;
            b_r     <= b;
            pipe[0] <= PW'(a_r) * PW'(b_r);
            for (int k = 1; k < LAT-1; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign p = pipe[LAT-2];

    // A zero limb in the A operand must give a zero product LAT cycles later (R1)
    assert_zero_limb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a, LAT) == '0) |-> (p == '0));
endmodule

// File: rtl/wm_bank.sv
// One bank of NY tiles. A single XL-bit limb is multiplied by every YL-bit limb
// of the padded Y operand. The tile outputs are aligned to their Y weights and
// summed into one row. The sum is combinational on the tile outputs.
module wm_bank #(
    parameter int XL  = 17,
    parameter int YL  = 26,
    parameter int NY  = 10,
    parameter int LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XL-1:0]        x_limb,
    input  logic [NY*YL-1:0]     y_pad,
    output logic [XL+NY*YL-1:0]  row
);
    localparam int PW    = XL + YL;
    localparam int ROW_W = XL + NY*YL;

    logic [PW-1:0] prod [NY];

    for (genvar j = 0; j < NY; j++) begin : g_tile
        wm_tile #(.AW(XL), .BW(YL), .LAT(LAT)) i_tile (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (x_limb),
            .b    (y_pad[j*YL +: YL]),
            .p    (prod[j])
        );
    end

    // Shift each tile product to its Y limb weight and add the products into one row
    always_comb begin
        row = '0;
        for (int j = 0; j < NY; j++) row = row + (ROW_W'(prod[j]) << (j*YL));
    end
endmodule

// File: rtl/wm_ctrl.sv
// Issue controller. It accepts a request, steps through STEPS issue cycles and
// re-opens in_ready on the last of them. It also delays each issue tag by LAT
// cycles so that the tag arrives together with the tile results.
module wm_ctrl
    import wm_pkg::*;
#(
    parameter int STEPS = 8,
    parameter int LAT   = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    output logic    in_ready,
    output logic    accept,
    output wm_tag_t issue_tag,
    output wm_tag_t row_tag
);
    localparam logic [WM_STEP_W-1:0] LAST_STEP = WM_STEP_W'(STEPS-1);

    logic                 busy;
    logic [WM_STEP_W-1:0] step;
    wm_tag_t              tag_pipe [LAT];

    assign in_ready = !busy || (step == LAST_STEP);
    assign accept   = in_valid && in_ready;

    // Issue tag for the current cycle
    always_comb begin
        issue_tag.vld   = busy;
        issue_tag.first = busy && (step == '0);
        issue_tag.last  = busy && (step == LAST_STEP);
        issue_tag.step  = step;
    end

    // Step counter: restart on accept, advance while busy, go idle after the last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            if (step == LAST_STEP) busy <= 1'b0;
            else                   step <= step + 1'b1;
        end
    end

    // Delay line that keeps the tags in step with the tile pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) tag_pipe[k] <= '0;
        end else begin
            tag_pipe[0] <= issue_tag;
            for (int k = 1; k < LAT; k++) tag_pipe[k] <= tag_pipe[k-1];
        end
    end

    assign row_tag = tag_pipe[LAT-1];

    // An accept always starts a fresh sequence at step 0 (R4)
    assert_accept_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && step == '0));

    // Rows of one operation arrive contiguously and in step order (R7)
    assert_row_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tag.vld && !row_tag.last) |=>
            (row_tag.vld && !row_tag.first && row_tag.step == $past(row_tag.step) + 1'b1));
endmodule

// File: rtl/wide_mul_tiled.sv
// Top of the tiled wide multiplier. It registers the operands on accept and
// feeds one X limb per bank in each issue cycle. It accumulates the shifted
// rows and presents the product with a one-cycle strobe.
// Assumes X_W and Y_W are at most the padded limb spans derived below.
module wide_mul_tiled
    import wm_pkg::*;
#(
    parameter int X_W   = 256,
    parameter int Y_W   = 256,
    parameter int XL    = 17,
    parameter int YL    = 26,
    parameter int BANKS = 2,
    parameter int LAT   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [X_W-1:0]     in_x,
    input  logic [Y_W-1:0]     in_y,
    output logic               out_valid,
    output logic [X_W+Y_W-1:0] out_prod
);
    localparam int NXL   = (X_W + XL - 1) / XL;
    localparam int NYL   = (Y_W + YL - 1) / YL;
    localparam int STEPS = (NXL + BANKS - 1) / BANKS;
    localparam int XPAD  = STEPS * BANKS * XL;
    localparam int YPAD  = NYL * YL;
    localparam int ROW_W = XL + YPAD;
    localparam int P_W   = X_W + Y_W;
    localparam int ACC_W = XPAD + YPAD;

    logic              accept;
    wm_tag_t           issue_tag;
    wm_tag_t           row_tag;
    logic [XPAD-1:0]   x_q;
    logic [YPAD-1:0]   y_q;
    logic [XL-1:0]     x_limb [BANKS];
    logic [ROW_W-1:0]  row [BANKS];
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_sum;

    wm_ctrl #(.STEPS(STEPS), .LAT(LAT)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .issue_tag(issue_tag),
        .row_tag  (row_tag)
    );

    // Capture the zero-extended operands when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (accept) begin
            x_q <= XPAD'(in_x);
            y_q <= YPAD'(in_y);
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Bank b takes X limbs b, b+BANKS, b+2*BANKS, ...
        assign x_limb[b] = x_q[(int'(issue_tag.step)*BANKS + b)*XL +: XL];

        wm_bank #(.XL(XL), .YL(YL), .NY(NYL), .LAT(LAT)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .x_limb(x_limb[b]),
            .y_pad (y_q),
            .row   (row[b])
        );
    end

    // Shift each bank row to its X limb weight and add it to the running sum
    always_comb begin
        acc_sum = row_tag.first ? '0 : acc;
        for (int b = 0; b < BANKS; b++)
            acc_sum = acc_sum + (ACC_W'(row[b]) << ((int'(row_tag.step)*BANKS + b)*XL));
    end

    // Accumulator update, and product capture with a strobe on the last row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            out_prod  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (row_tag.vld) begin
                acc <= acc_sum;
                if (row_tag.last) begin
                    out_prod  <= acc_sum[P_W-1:0];
                    out_valid <= 1'b1;
                end
            end
        end
    end

    // Nothing may spill above the product width when a result completes (R3)
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tag.vld && row_tag.last) |-> (acc_sum[ACC_W-1:P_W] == '0));

    // The done strobe lasts one cycle (R5)
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // The product holds between strobes (R8)
    assert_prod_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_prod));
endmodule

// File: tb/test_wide_mul_tiled.sv
`timescale 1ns/1ps
// Bench with a behavioural model. A queue of expected products, each with its
// due edge, and a count of remaining issue cycles are compared every clock.
module test_wide_mul_tiled;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_x = '0;
    logic [255:0] in_y = '0;
    logic         out_valid;
    logic [511:0] out_prod;

    int total = 0;
    int bad = 0;
    int edges = 0;
    int rem = 0;
    bit finished = 1'b0;
    logic [511:0] last_prod = '0;
    logic [511:0] q_val [$];
    int           q_due [$];

    always #2 clk = ~clk;

    wide_mul_tiled i_wide_mul_tiled (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_prod(out_prod)
    );

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // One clock: check the outputs after the edge, then drive the next request
    task automatic tick(input bit v, input logic [255:0] x, input logic [255:0] y);
        bit exp_rdy;
        bit exp_v;
        @(negedge clk);
        edges++;
        exp_rdy = (rem <= 1);
        total++;
        if (in_ready !== exp_rdy) begin
            bad++;
            $display("FAIL R4 edge %0d: in_ready=%b expected %b", edges, in_ready, exp_rdy);
        end
        exp_v = (q_due.size() > 0) && (q_due[0] == edges);
        total++;
        if (out_valid !== exp_v) begin
            bad++;
            $display("FAIL R2/R5 edge %0d: out_valid=%b expected %b", edges, out_valid, exp_v);
        end
        if (exp_v) begin
            total++;
            if (out_prod !== q_val[0]) begin
                bad++;
                $display("FAIL R1/R7 edge %0d: out_prod=%h expected %h", edges, out_prod, q_val[0]);
            end
            last_prod = q_val[0];
            void'(q_val.pop_front());
            void'(q_due.pop_front());
        end else begin
            total++;
            if (out_prod !== last_prod) begin
                bad++;
                $display("FAIL R8 edge %0d: out_prod=%h expected %h", edges, out_prod, last_prod);
            end
        end
        in_valid = v;
        in_x = x;
        in_y = y;
        if (v && exp_rdy) begin
            q_val.push_back({256'b0, x} * {256'b0, y});
            q_due.push_back(edges + 12);
            rem = 8;
        end else if (rem > 0) begin
            rem--;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R6: reset state
        total++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0 || out_prod !== '0) begin
            bad++;
            $display("FAIL R6: ready=%b valid=%b prod=%h expected 1 0 0", in_ready, out_valid, out_prod);
        end
        rst_n = 1'b1;
        idle(2);
        // R1: zero operands, then all-ones (largest carry, R3)
        tick(1'b1, '0, '0);               idle(14);
        tick(1'b1, '1, '1);               idle(14);
        // R1: single set bits at both ends of each operand
        tick(1'b1, 256'b1 << 255, 256'b1 << 255); idle(14);
        tick(1'b1, 256'd1, 256'b1 << 255);        idle(14);
        tick(1'b1, 256'b1 << 255, 256'd1);        idle(14);
        tick(1'b1, 256'd1, 256'd1);               idle(14);
        tick(1'b1, '1, 256'd1);                   idle(14);
        // R4/R7: in_valid held with new random operands every cycle; busy-cycle requests are ignored
        for (int i = 0; i < 120; i++) tick(1'b1, rnd256(), rnd256());
        idle(14);
        // R2: isolated random operations with idle gaps
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, rnd256(), rnd256());
            idle(3 + i);
        end
        // R7: back-to-back all-ones and zeros so a stale partial sum would show
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, (i % 2 == 0) ? '1 : '0, '1);
            idle(7);
        end
        idle(16);
        total++;
        if (q_due.size() != 0) begin
            bad++;
            $display("FAIL R2: %0d results missing, expected 0", q_due.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule